// File: doc/BRIEF.md
# Receive-to-Transmit Word Repeater Path

This block joins the receive side of a serial avionics word receiver to its transmit word queue. A host fetches each received 32-bit word as two 16-bit halves, choosing the half with a select input. In repeater mode, every half the host fetches is also captured, and once the upper half arrives the whole word is pushed into the transmit queue. The host therefore forwards a word without writing it a second time.

The block holds a small receive queue that overwrites its newest entry when a word arrives while it is full. It also holds a transmit queue that drops writes when full. A self-test loopback sends the transmitter's serial bit either to the two receiver inputs or lets the external line inputs through. When self-test is active, one receiver input gets the true bit and the other gets the inverted bit.

Top module: `rptr_path`

## Requirements
- R1: After a synchronous active-low reset, `rx_ready` is 0, `rx_count` and `tx_count` are 0, `tx_empty` is 1, `tx_full` is 0 and `rep_err` is 0.
- R2: While the receive queue is not empty, `rd_data` shows bits 15:0 of the oldest word when `half_sel` is 0 and bits 31:16 when `half_sel` is 1.
- R3: In normal mode (`rep_mode`=0) either half may be read first. A word leaves the receive queue at the clock edge of the read that completes both halves. Reading the same half again does not remove the word. Normal reads never write the transmit queue.
- R4: In repeater mode, a lower-half read followed by an upper-half read of the same word writes {upper,lower} into the transmit queue at the upper read's edge. It also removes the word from the receive queue. The word is visible at `tx_head` one cycle later when the queue was empty.
- R5: In repeater mode, an upper-half read with no lower-half read of that word before it raises `rep_err` during the read cycle and writes nothing to the transmit queue.
- R6: A word written while the receive queue holds `RX_DEPTH` words and no entry is removed in that cycle replaces the newest stored word. Older words are kept and the count stays at `RX_DEPTH`.
- R7: `rx_ready` falls in the cycle after the read that removes the last stored word.
- R8: While the transmit queue holds `TX_DEPTH` words, host writes and repeater writes are dropped and the stored words are unchanged.
- R9: When a repeater write and a host write fall in the same cycle, the repeater word is stored and the host word is dropped.
- R10: With `self_test_n`=0, `rx1_bit` equals `tx_serial` and `rx2_bit` equals its inverse, and the line inputs have no effect. With `self_test_n`=1, `rx1_bit`=`line1` and `rx2_bit`=`line2`. `tx_line` always equals `tx_serial`.
- R11: A read strobe while the receive queue is empty changes no count and raises no `rep_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rep_mode | input | 1 | 1 = repeater mode |
| self_test_n | input | 1 | 0 = internal loopback |
| rx_wr | input | 1 | Received word strobe |
| rx_word | input | 32 | Received word |
| rd_en | input | 1 | Host half-read strobe |
| half_sel | input | 1 | 0 = lower half, 1 = upper half |
| rd_data | output | 16 | Selected half of oldest word |
| rx_ready | output | 1 | Receive queue not empty |
| rx_count | output | clog2(RX_DEPTH+1) | Stored received words |
| rep_err | output | 1 | Out-of-order upper read in repeater mode |
| host_wr | input | 1 | Host transmit write strobe |
| host_word | input | 32 | Host transmit word |
| tx_rd | input | 1 | Transmitter takes head word |
| tx_head | output | 32 | Oldest transmit word |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_count | output | clog2(TX_DEPTH+1) | Stored transmit words |
| tx_serial | input | 1 | Transmitter serial bit |
| line1 | input | 1 | External receiver 1 bit |
| line2 | input | 1 | External receiver 2 bit |
| rx1_bit | output | 1 | Bit fed to receiver 1 |
| rx2_bit | output | 1 | Bit fed to receiver 2 |
| tx_line | output | 1 | Transmitter line bit |

## Verification
A stale half-done flag shows up at the ports on the next read. The word is either removed one read early, which moves `rx_count` and `rd_data` to the next word in the following cycle, or it lingers for an extra read. A wrong captured lower half appears at `tx_head` one cycle after the upper read. A wrong overwrite pointer corrupts an older word, and that word is seen as soon as the host reads it. Loopback errors are combinational and show in the same cycle.

// File: rtl/rptr_pkg.sv
// Shared widths and half-select encoding for the repeater path.
// Assumes 32-bit words split into two 16-bit halves.
package rptr_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/rptr_word_fifo.sv
// Word queue with an optional overwrite-when-full policy.
// Assumes DEPTH is a power of two. A read and a write in the same cycle
// both take effect. When full with no read, a write replaces the newest
// entry if OVERWRITE is set, and is dropped otherwise.
module rptr_word_fifo #(
    parameter int DEPTH     = 4,
    parameter int WIDTH     = 32,
    parameter bit OVERWRITE = 1'b0,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic             do_rd, do_wr, ovw;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign do_rd = rd && !empty;
    assign do_wr = wr && (!full || do_rd);
    assign rdata = mem[rptr];

    generate
        if (OVERWRITE) begin : g_ovw
            assign ovw = wr && full && !do_rd;
        end else begin : g_drop
            assign ovw = 1'b0;
        end
    endgenerate

    // Storage: append at the tail, or replace the newest entry when overwriting.
    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wptr] <= wdata;
        else if (ovw)
            mem[wptr - PW'(1)] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= wptr + PW'(1);
            if (do_rd) rptr <= rptr + PW'(1);
            if (do_wr && !do_rd)      count <= count + CW'(1);
            else if (do_rd && !do_wr) count <= count - CW'(1);
        end
    end

    // R6 / R8: a write into a full queue with no read leaves it full.
    a_r6_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd) |=> full);

    // R11: a read of an empty queue without a write leaves it empty.
    a_r11_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd && !wr) |=> empty);
endmodule

// File: rtl/rptr_half_ctl.sv
// Half-word read mux, per-word read tracking and repeater capture.
// Assumes head/empty come from the receive queue. A word is popped when
// both halves have been read. In repeater mode the lower half is held
// and the full word is committed on the upper read.
module rptr_half_ctl
    import rptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rep_mode,
    input  logic              rd_en,
    input  logic              half_sel,
    input  logic [WORD_W-1:0] head,
    input  logic              empty,
    output logic [HALF_W-1:0] rd_data,
    output logic              pop,
    output logic              commit,
    output logic [WORD_W-1:0] commit_word,
    output logic              rep_err
);
    logic              rd_ok, lo_mark, hi_mark;
    logic              lo_done, hi_done, lo_valid;
    logic [HALF_W-1:0] lo_hold;

    assign rd_ok   = rd_en && !empty;
    assign lo_mark = rd_ok && (half_e'(half_sel) == HALF_LO);
    assign hi_mark = rd_ok && (half_e'(half_sel) == HALF_HI);
    assign rd_data = (half_e'(half_sel) == HALF_HI) ? head[WORD_W-1:HALF_W]
                                                     : head[HALF_W-1:0];
    assign pop     = (lo_mark && hi_done) || (hi_mark && lo_done);
    assign commit  = rep_mode && hi_mark && lo_valid;
    assign rep_err = rep_mode && hi_mark && !lo_valid;
    assign commit_word = {head[WORD_W-1:HALF_W], lo_hold};

    // Track which halves of the head word have been read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_done <= 1'b0;
            hi_done <= 1'b0;
        end else if (pop) begin
            lo_done <= 1'b0;
            hi_done <= 1'b0;
        end else begin
            if (lo_mark) lo_done <= 1'b1;
            if (hi_mark) hi_done <= 1'b1;
        end
    end

    // Repeater capture of the lower half, valid until its word leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_valid <= 1'b0;
            lo_hold  <= '0;
        end else begin
            if (!rep_mode || pop) lo_valid <= 1'b0;
            else if (lo_mark)     lo_valid <= 1'b1;
            if (lo_mark) lo_hold <= head[HALF_W-1:0];
        end
    end

    // R3: after a pop the next word starts with no half read.
    a_r3_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (!lo_done && !hi_done));

    // R4: a repeater commit always completes (pops) its word.
    a_r4_commit_pops: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> pop);
endmodule

// File: rtl/rptr_loopback.sv
// Self-test routing of the transmit bit to the two receiver inputs.
// Active-low test select: 0 routes true/inverted transmit bit internally.
module rptr_loopback (
    input  logic self_test_n,
    input  logic tx_serial,
    input  logic line1,
    input  logic line2,
    output logic rx1_bit,
    output logic rx2_bit,
    output logic tx_line
);
    // Select receiver sources; transmit line is never gated.
    always_comb begin
        rx1_bit = self_test_n ? line1 : tx_serial;
        rx2_bit = self_test_n ? line2 : ~tx_serial;
        tx_line = tx_serial;
        if (!self_test_n)
            a_r10_inverted_pair: assert (rx2_bit != rx1_bit);
    end
endmodule

// File: rtl/rptr_path.sv
// Top of the receive-to-transmit repeater path. Receive queue overwrites
// its newest word when full; transmit queue drops writes when full.
// A repeater commit takes priority over a host write in the same cycle.
module rptr_path
    import rptr_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 32,
    localparam int RXC_W = $clog2(RX_DEPTH + 1),
    localparam int TXC_W = $clog2(TX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rep_mode,
    input  logic              self_test_n,
    input  logic              rx_wr,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rd_en,
    input  logic              half_sel,
    output logic [HALF_W-1:0] rd_data,
    output logic              rx_ready,
    output logic [RXC_W-1:0]  rx_count,
    output logic              rep_err,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_word,
    input  logic              tx_rd,
    output logic [WORD_W-1:0] tx_head,
    output logic              tx_empty,
    output logic              tx_full,
    output logic [TXC_W-1:0]  tx_count,
    input  logic              tx_serial,
    input  logic              line1,
    input  logic              line2,
    output logic              rx1_bit,
    output logic              rx2_bit,
    output logic              tx_line
);
    logic [WORD_W-1:0] rx_head, rep_word, tx_wdata;
    logic              rx_empty, rx_full, rx_pop, rep_commit, tx_wr;

    assign rx_ready = !rx_empty;
    assign tx_wr    = rep_commit || host_wr;
    assign tx_wdata = rep_commit ? rep_word : host_word;

    rptr_word_fifo #(.DEPTH(RX_DEPTH), .WIDTH(WORD_W), .OVERWRITE(1'b1)) rx_q (
        .clk(clk), .rst_n(rst_n), .wr(rx_wr), .wdata(rx_word), .rd(rx_pop),
        .rdata(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty));

    rptr_half_ctl half_i (
        .clk(clk), .rst_n(rst_n), .rep_mode(rep_mode), .rd_en(rd_en),
        .half_sel(half_sel), .head(rx_head), .empty(rx_empty),
        .rd_data(rd_data), .pop(rx_pop), .commit(rep_commit),
        .commit_word(rep_word), .rep_err(rep_err));

    rptr_word_fifo #(.DEPTH(TX_DEPTH), .WIDTH(WORD_W), .OVERWRITE(1'b0)) tx_q (
        .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_wdata), .rd(tx_rd),
        .rdata(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty));

    rptr_loopback loop_i (
        .self_test_n(self_test_n), .tx_serial(tx_serial), .line1(line1),
        .line2(line2), .rx1_bit(rx1_bit), .rx2_bit(rx2_bit), .tx_line(tx_line));

    // R4: a commit into a non-full, non-draining queue adds one word.
    a_r4_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_commit && !tx_full && !tx_rd) |=> tx_count == $past(tx_count) + TXC_W'(1));

    // R7: removing the last word without a new arrival drops ready.
    a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_count == RXC_W'(1) && !rx_wr) |=> !rx_ready);

    // R6: the receive queue never reports more than its depth.
    a_r6_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= RXC_W'(RX_DEPTH));
endmodule

// File: tb/rptr_path_tb_top.sv
module rptr_path_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rep_mode = 1'b0, self_test_n = 1'b1;
    logic        rx_wr = 1'b0, rd_en = 1'b0, half_sel = 1'b0;
    logic [31:0] rx_word = '0, host_word = '0;
    logic        host_wr = 1'b0, tx_rd = 1'b0;
    logic        tx_serial = 1'b0, line1 = 1'b0, line2 = 1'b0;
    logic [15:0] rd_data;
    logic        rx_ready, rep_err, tx_empty, tx_full, rx1_bit, rx2_bit, tx_line;
    logic [2:0]  rx_count;
    logic [5:0]  tx_count;
    logic [31:0] tx_head;
    int          vec = 0, bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    rptr_path dut_i (
        .clk(clk), .rst_n(rst_n), .rep_mode(rep_mode), .self_test_n(self_test_n),
        .rx_wr(rx_wr), .rx_word(rx_word), .rd_en(rd_en), .half_sel(half_sel),
        .rd_data(rd_data), .rx_ready(rx_ready), .rx_count(rx_count),
        .rep_err(rep_err), .host_wr(host_wr), .host_word(host_word),
        .tx_rd(tx_rd), .tx_head(tx_head), .tx_empty(tx_empty), .tx_full(tx_full),
        .tx_count(tx_count), .tx_serial(tx_serial), .line1(line1), .line2(line2),
        .rx1_bit(rx1_bit), .rx2_bit(rx2_bit), .tx_line(tx_line));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push_rx(input logic [31:0] w);
        @(negedge clk); rx_wr = 1'b1; rx_word = w;
        @(negedge clk); rx_wr = 1'b0;
    endtask

    // One half read; rd_data checked in the strobe cycle.
    task automatic read_half(input logic h, input logic [15:0] exp, input string req);
        @(negedge clk); rd_en = 1'b1; half_sel = h;
        #1 chk(req, "rd_data", {16'h0, rd_data}, {16'h0, exp});
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pop_tx;
        @(negedge clk); tx_rd = 1'b1;
        @(negedge clk); tx_rd = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk("R1", "rx_ready", {31'h0, rx_ready}, 32'h0);
        chk("R1", "rx_count", {29'h0, rx_count}, 32'h0);
        chk("R1", "tx_count", {26'h0, tx_count}, 32'h0);
        chk("R1", "tx_empty", {31'h0, tx_empty}, 32'h1);
        chk("R1", "tx_full", {31'h0, tx_full}, 32'h0);
        chk("R1", "rep_err", {31'h0, rep_err}, 32'h0);
    endtask

    task automatic t_normal;
        rep_mode = 1'b0;
        push_rx(32'h1234_5678);
        chk("R7", "rx_ready set", {31'h0, rx_ready}, 32'h1);
        read_half(1'b1, 16'h1234, "R2");
        read_half(1'b1, 16'h1234, "R3");
        chk("R3", "word kept after repeat half", {29'h0, rx_count}, 32'h1);
        read_half(1'b0, 16'h5678, "R2");
        chk("R3", "word removed", {29'h0, rx_count}, 32'h0);
        chk("R7", "rx_ready cleared", {31'h0, rx_ready}, 32'h0);
        chk("R3", "no tx write", {26'h0, tx_count}, 32'h0);
        push_rx(32'hAAAA_BBBB);
        push_rx(32'hCCCC_DDDD);
        read_half(1'b0, 16'hBBBB, "R3");
        read_half(1'b1, 16'hAAAA, "R3");
        chk("R3", "one left", {29'h0, rx_count}, 32'h1);
        read_half(1'b0, 16'hDDDD, "R3");
        read_half(1'b1, 16'hCCCC, "R3");
        chk("R7", "empty again", {31'h0, rx_ready}, 32'h0);
    endtask

    task automatic t_repeat;
        rep_mode = 1'b1;
        push_rx(32'hCAFE_BEEF);
        read_half(1'b0, 16'hBEEF, "R4");
        chk("R4", "no commit on lower", {26'h0, tx_count}, 32'h0);
        read_half(1'b1, 16'hCAFE, "R4");
        chk("R4", "tx_count", {26'h0, tx_count}, 32'h1);
        chk("R4", "tx_head", tx_head, 32'hCAFE_BEEF);
        chk("R4", "rx consumed", {29'h0, rx_count}, 32'h0);
        pop_tx();
        rep_mode = 1'b0;
    endtask

    task automatic t_bad_order;
        rep_mode = 1'b1;
        push_rx(32'h5555_6666);
        @(negedge clk); rd_en = 1'b1; half_sel = 1'b1;
        #1 chk("R5", "rep_err on upper first", {31'h0, rep_err}, 32'h1);
        @(negedge clk); rd_en = 1'b0;
        chk("R5", "no tx write", {26'h0, tx_count}, 32'h0);
        @(negedge clk); rd_en = 1'b1; half_sel = 1'b0;
        #1 chk("R5", "no rep_err on lower", {31'h0, rep_err}, 32'h0);
        @(negedge clk); rd_en = 1'b0;
        chk("R5", "still no tx write", {26'h0, tx_count}, 32'h0);
        chk("R5", "word consumed", {29'h0, rx_count}, 32'h0);
        rep_mode = 1'b0;
    endtask

    task automatic t_overwrite;
        rep_mode = 1'b0;
        for (int k = 0; k < 5; k++) push_rx(32'h0101_0101 * (k + 1));
        chk("R6", "count held at depth", {29'h0, rx_count}, 32'h4);
        for (int k = 0; k < 3; k++) begin
            read_half(1'b0, 16'h0101 * (k + 1), "R6");
            read_half(1'b1, 16'h0101 * (k + 1), "R6");
        end
        read_half(1'b0, 16'h0505, "R6");
        read_half(1'b1, 16'h0505, "R6");
        chk("R6", "drained", {29'h0, rx_count}, 32'h0);
    endtask

    task automatic t_empty_read;
        rep_mode = 1'b1;
        @(negedge clk); rd_en = 1'b1; half_sel = 1'b1;
        #1 chk("R11", "rep_err on empty", {31'h0, rep_err}, 32'h0);
        @(negedge clk); rd_en = 1'b0;
        chk("R11", "rx_count", {29'h0, rx_count}, 32'h0);
        chk("R11", "tx_count", {26'h0, tx_count}, 32'h0);
        rep_mode = 1'b0;
    endtask

    task automatic t_priority;
        rep_mode = 1'b1;
        push_rx(32'h7777_8888);
        read_half(1'b0, 16'h8888, "R9");
        @(negedge clk); rd_en = 1'b1; half_sel = 1'b1;
        host_wr = 1'b1; host_word = 32'h9999_0000;
        @(negedge clk); rd_en = 1'b0; host_wr = 1'b0;
        chk("R9", "single word stored", {26'h0, tx_count}, 32'h1);
        chk("R9", "repeater word wins", tx_head, 32'h7777_8888);
        pop_tx();
        rep_mode = 1'b0;
    endtask

    task automatic t_tx_full;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk); host_wr = 1'b1; host_word = 32'h1000_0000 + k;
        end
        @(negedge clk); host_wr = 1'b0;
        chk("R8", "tx_full", {31'h0, tx_full}, 32'h1);
        @(negedge clk); host_wr = 1'b1; host_word = 32'hDEAD_DEAD;
        @(negedge clk); host_wr = 1'b0;
        chk("R8", "host write dropped", {26'h0, tx_count}, 32'd32);
        rep_mode = 1'b1;
        push_rx(32'hBEEF_F00D);
        read_half(1'b0, 16'hF00D, "R8");
        read_half(1'b1, 16'hBEEF, "R8");
        chk("R8", "repeater write dropped", {26'h0, tx_count}, 32'd32);
        rep_mode = 1'b0;
        chk("R8", "head unchanged", tx_head, 32'h1000_0000);
        for (int k = 0; k < 31; k++) pop_tx();
        chk("R8", "last stored word", tx_head, 32'h1000_001F);
        pop_tx();
        chk("R8", "drained", {31'h0, tx_empty}, 32'h1);
    endtask

    task automatic t_loop;
        @(negedge clk); self_test_n = 1'b0; tx_serial = 1'b1; line1 = 1'b0; line2 = 1'b1;
        #1;
        chk("R10", "rx1 true", {31'h0, rx1_bit}, 32'h1);
        chk("R10", "rx2 inverted", {31'h0, rx2_bit}, 32'h0);
        chk("R10", "tx_line", {31'h0, tx_line}, 32'h1);
        tx_serial = 1'b0; line1 = 1'b1; line2 = 1'b0;
        #1;
        chk("R10", "rx1 ignores line", {31'h0, rx1_bit}, 32'h0);
        chk("R10", "rx2 ignores line", {31'h0, rx2_bit}, 32'h1);
        self_test_n = 1'b1; tx_serial = 1'b1;
        #1;
        chk("R10", "rx1 from line", {31'h0, rx1_bit}, 32'h1);
        chk("R10", "rx2 from line", {31'h0, rx2_bit}, 32'h0);
        chk("R10", "tx_line normal", {31'h0, tx_line}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_repeat();
        t_bad_order();
        t_overwrite();
        t_empty_read();
        t_priority();
        t_tx_full();
        t_loop();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vec++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule